// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between a serial-bus slave front end and a byte-wide non-volatile array. When the front end has decoded a write command and its word address, it pulses `wr_begin`. The block then gathers up to sixteen data bytes in a page-sized staging buffer. The low address bits pick each byte's slot, and the page number stays fixed. Nothing reaches the array while bytes arrive. Only a stop strobe that closes the write moves the staged bytes into the array. The commit is one array write per cycle, inside a self-timed window of `WCYC` clock cycles. During that window `busy` is high. The front end uses `busy` to stop acknowledging its own slave address, and the block ignores every bus event that arrives in the window.

A new start condition before the stop throws away the staged bytes. A stop that closes a sequence with no data bytes does nothing. A high write-protect level at the stop also does nothing: the array is not changed and no busy window opens.

The controller has four states. `ST_IDLE` waits for a write. `ST_LOAD` collects bytes. `ST_COMMIT` scans the sixteen buffer slots in ascending order and writes each occupied one. `ST_HOLD` waits out the rest of the timed window. The transitions are as follows:
- IDLE→LOAD on `wr_begin`.
- LOAD→LOAD, with the buffer reloaded, on a further `wr_begin`.
- LOAD→IDLE on `start_evt`, or on a stop that has no data or has `wp` high.
- LOAD→COMMIT on a stop with data and `wp` low.
- COMMIT→HOLD after slot 15. COMMIT→IDLE instead if the window also ends at slot 15.
- HOLD→IDLE when the window timer runs out.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, `busy` and `mem_we` are both 0.
- R2: The first data byte goes to slot `wr_addr[3:0]`. The slot then increases by one per byte and wraps from 15 to 0. Each slot is committed at array address {`wr_addr[AW-1:4]`, slot}, with the upper bits unchanged. AW is log2 of the density parameter `WORDS`.
- R3: When more than 16 bytes arrive, a slot written twice commits the byte written last.
- R4: Only slots written during the current sequence are committed, one per cycle, in ascending slot order. The first array write happens in the cycle after the stop is sampled.
- R5: A stop in a sequence that has no data bytes causes no array write and leaves `busy` low.
- R6: A `start_evt` that arrives before the stop discards the staged bytes. A later stop then writes nothing.
- R7: When `wp` is 1 at the stop, nothing is written and `busy` stays low.
- R8: A committing stop raises `busy` in the next cycle. `busy` stays high for exactly `WCYC` cycles, and every `mem_we` pulse falls inside that window.
- R9: While `busy` is high, `wr_begin`, `byte_vld`, `start_evt` and `stop_evt` have no effect. They cause no extra writes, do not change the window length, and leave nothing staged that a later stop could commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_begin | input | 1 | Write command and word address decoded; one-cycle strobe |
| wr_addr | input | log2(WORDS) | Word address, valid with `wr_begin` |
| byte_vld | input | 1 | Data byte received; one-cycle strobe |
| byte_data | input | 8 | Received data byte |
| start_evt | input | 1 | Start condition seen on the bus |
| stop_evt | input | 1 | Stop condition seen on the bus |
| wp | input | 1 | Write protect level; 1 locks the array |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | log2(WORDS) | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write window active |

## Verification
The bench builds the block with `WORDS=2048`, which gives an 11-bit address, so pages near the top of the largest array carry their upper bits through to the array address. It uses `WCYC=24`, eight cycles longer than the commit scan. That keeps the window short enough to run many sequences, and it leaves a tail in `ST_HOLD` in which bus noise can be injected after the last array write. With the default page of 16, a 20-byte burst wraps and overwrites slots. A start address of 14 wraps across the page edge.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HOLD   = 2'd3
    } pg_state_e;

endpackage

// File: rtl/pgwr_buf.sv
// Page staging storage: one byte and one occupancy flag per slot.
module pgwr_buf #(
    parameter int PAGE = 16,
    parameter int PW   = $clog2(PAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wen,
    input  logic [PW-1:0] wofs,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] rofs,
    output logic [7:0]    rdata,
    output logic          rvld,
    output logic          any
);

    logic [PAGE-1:0] mask;
    logic [7:0]      ent [PAGE];

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        logic [7:0] d_q;
        logic       v_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 8'h00;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (wen && wofs == PW'(g)) begin
                v_q <= 1'b1;
                d_q <= wdata;
            end
        end
        assign mask[g] = v_q;
        assign ent[g]  = d_q;
    end

    assign rdata = ent[rofs];
    assign rvld  = mask[rofs];
    assign any   = |mask;

endmodule

// File: rtl/pgwr_tmr.sv
// Down counter that measures the self-timed write window.
module pgwr_tmr #(
    parameter int WCYC = 64,
    parameter int CW   = $clog2(WCYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(WCYC - 1);
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int WORDS = 256,
    parameter int PAGE  = 16,
    parameter int WCYC  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_begin,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic                     byte_vld,
    input  logic [7:0]               byte_data,
    input  logic                     start_evt,
    input  logic                     stop_evt,
    input  logic                     wp,
    output logic                     mem_we,
    output logic [$clog2(WORDS)-1:0] mem_addr,
    output logic [7:0]               mem_wdata,
    output logic                     busy
);

    localparam int AW = $clog2(WORDS);
    localparam int PW = $clog2(PAGE);
    localparam int HW = AW - PW;

    pg_state_e     st_q, st_d;
    logic [HW-1:0] page_q;
    logic [PW-1:0] ofs_q;
    logic [PW-1:0] idx_q;

    logic          buf_clr, buf_wen, buf_rvld, buf_any;
    logic [7:0]    buf_rdata;
    logic          tmr_load, tmr_zero;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Next state and control strobes
    always_comb begin
        st_d     = st_q;
        buf_clr  = 1'b0;
        buf_wen  = 1'b0;
        tmr_load = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_begin) begin
                    st_d    = ST_LOAD;
                    buf_clr = 1'b1;
                end
            end
            ST_LOAD: begin
                if (wr_begin) begin
                    buf_clr = 1'b1;
                end else if (start_evt) begin
                    st_d = ST_IDLE;
                end else if (stop_evt) begin
                    if (buf_any && !wp) begin
                        st_d     = ST_COMMIT;
                        tmr_load = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else if (byte_vld) begin
                    buf_wen = 1'b1;
                end
            end
            ST_COMMIT: begin
                if (idx_q == PW'(PAGE - 1))
                    st_d = tmr_zero ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_zero)
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Address tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
            idx_q  <= '0;
        end else begin
            if (buf_clr)
                {page_q, ofs_q} <= wr_addr;
            else if (buf_wen)
                ofs_q <= ofs_q + 1'b1;
            if (tmr_load)
                idx_q <= '0;
            else if (st_q == ST_COMMIT)
                idx_q <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy      = (st_q == ST_COMMIT) || (st_q == ST_HOLD);
        mem_we    = (st_q == ST_COMMIT) && buf_rvld;
        mem_addr  = {page_q, idx_q};
        mem_wdata = buf_rdata;
    end

    pgwr_buf #(.PAGE(PAGE), .PW(PW)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .wen   (buf_wen),
        .wofs  (ofs_q),
        .wdata (byte_data),
        .rofs  (idx_q),
        .rdata (buf_rdata),
        .rvld  (buf_rvld),
        .any   (buf_any)
    );

    pgwr_tmr #(.WCYC(WCYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (busy),
        .zero  (tmr_zero)
    );

endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
    parameter int WORDS = 256,
    parameter int PAGE  = 16,
    parameter int WCYC  = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wp,
    input logic                     stop_evt,
    input logic                     mem_we,
    input logic [$clog2(WORDS)-1:0] mem_addr,
    input logic                     busy
);

    localparam int AW = $clog2(WORDS);
    localparam int PW = $clog2(PAGE);
    localparam int BW = $clog2(WCYC + 1) + 1;

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bcnt <= '0;
        else if (!busy)
            bcnt <= '0;
        else
            bcnt <= bcnt + 1'b1;
    end

    assert_we_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_window_opens_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    assert_window_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == BW'(WCYC)));

    assert_window_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < BW'(WCYC)));

    assert_protect_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && wp) |=> !busy);

    assert_ascending_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW])) &&
            (mem_addr[PW-1:0] > $past(mem_addr[PW-1:0])));

endmodule

bind pgwr_seq pgwr_chk #(.WORDS(WORDS), .PAGE(PAGE), .WCYC(WCYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp       (wp),
    .stop_evt (stop_evt),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .busy     (busy)
);

// File: tb/sim_pgwr_seq.sv
module sim_pgwr_seq;

    localparam int WORDS = 2048;
    localparam int PAGE  = 16;
    localparam int WCYC  = 24;
    localparam int AW    = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_begin = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = 8'h00;
    logic          start_evt = 1'b0;
    logic          stop_evt = 1'b0;
    logic          wp = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [AW-1:0] a;
        logic [7:0]    d;
    } exp_t;
    exp_t sb [$];

    always #5 clk = ~clk;

    pgwr_seq #(.WORDS(WORDS), .PAGE(PAGE), .WCYC(WCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .start_evt(start_evt),
        .stop_evt(stop_evt), .wp(wp), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: every array write is popped from the scoreboard and compared
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            check(busy, "R8", "write outside busy window", 0, 1);
            if (sb.size() == 0) begin
                check(1'b0, "R4", "unexpected array write addr", int'(mem_addr), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(mem_addr == e.a, "R2", "write address", int'(mem_addr), int'(e.a));
                check(mem_wdata == e.d, "R3", "write data", int'(mem_wdata), int'(e.d));
            end
        end
    end

    // Counts busy-high negedges after a stop; returns the window length
    task automatic window_len(output int len, input bit noise);
        len = 0;
        while (busy && len < WCYC + 8) begin
            len++;
            if (noise) begin
                wr_begin  = (len % 4 == 1);
                wr_addr   = 11'h055;
                byte_vld  = 1'b1;
                byte_data = 8'hEE;
                stop_evt  = (len % 4 == 3);
                start_evt = (len % 4 == 0);
            end
            @(negedge clk);
        end
        wr_begin = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0; start_evt = 1'b0;
    endtask

    // kind: 0 = normal write, 1 = start before stop, 2 = write protected
    task automatic write_seq(input logic [AW-1:0] addr, input int n,
                             input logic [7:0] base, input int kind, input string req);
        logic [7:0] sh [PAGE];
        bit         shv [PAGE];
        int         ofs;
        int         len;
        bit         commit;
        for (int i = 0; i < PAGE; i++) begin sh[i] = 8'h00; shv[i] = 1'b0; end
        ofs = int'(addr[3:0]);
        for (int i = 0; i < n; i++) begin
            sh[ofs] = base + 8'(i);
            shv[ofs] = 1'b1;
            ofs = (ofs + 1) % PAGE;
        end
        commit = (kind == 0) && (n > 0);
        if (commit)
            for (int i = 0; i < PAGE; i++)
                if (shv[i]) sb.push_back('{a: {addr[AW-1:4], 4'(i)}, d: sh[i]});

        wp = (kind == 2);
        wr_begin = 1'b1; wr_addr = addr;
        @(negedge clk);
        wr_begin = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_data = base + 8'(i);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        if (kind == 1) begin
            start_evt = 1'b1;
            @(negedge clk);
            start_evt = 1'b0;
        end
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        check(busy == commit, req, "busy one cycle after stop", int'(busy), int'(commit));
        window_len(len, 1'b0);
        check(len == (commit ? WCYC : 0), "R8", "busy window length", len, commit ? WCYC : 0);
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R4", "writes still pending", sb.size(), 0);
        wp = 1'b0;
    endtask

    initial begin
        #(20_000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1", "busy after reset", int'(busy), 0);
        check(!mem_we, "R1", "mem_we after reset", int'(mem_we), 0);

        write_seq(11'h125, 4, 8'hA0, 0, "R2");   // slots 5..8
        write_seq(11'h7FE, 4, 8'h10, 0, "R2");   // wrap 14,15,0,1
        write_seq(11'h300, 20, 8'h40, 0, "R3");  // overfill, slots 0..3 rewritten
        write_seq(11'h412, 1, 8'h77, 0, "R4");   // single byte
        write_seq(11'h500, 0, 8'h00, 0, "R5");   // stop without data
        write_seq(11'h600, 3, 8'h20, 1, "R6");   // start discards
        write_seq(11'h6A0, 5, 8'h30, 2, "R7");   // write protected

        // R9: bus activity inside the window is ignored
        sb.push_back('{a: 11'h0F3, d: 8'h99});
        wr_begin = 1'b1; wr_addr = 11'h0F3;
        @(negedge clk);
        wr_begin = 1'b0; byte_vld = 1'b1; byte_data = 8'h99;
        @(negedge clk);
        byte_vld = 1'b0; stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        window_len(len, 1'b1);
        check(len == WCYC, "R9", "window length with bus noise", len, WCYC);
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        check(!busy, "R9", "stop after noisy window committed", int'(busy), 0);
        repeat (WCYC) @(negedge clk);
        check(sb.size() == 0, "R9", "writes pending after noise", sb.size(), 0);

        write_seq(11'h0A8, 3, 8'h61, 0, "R4");   // normal write after all that

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule